// File: doc/BRIEF.md
# Routed External Interrupt Controller

This block gathers a vector of level-sensitive external interrupt sources and delivers each one to one of several cores, on one of several interrupt pins of that core. Two sets of routing registers settle where a source goes. A per-source core map picks the destination core. A per-group pin map picks the destination pin for a group of 32 sources. Each routing field is a one-hot nibble that is decoded by its lowest set bit. A nibble with no bit set falls back to index 0.

A source that becomes active while its enable bit is set is delivered at once. Delivery sets the source's bit in the status word of its destination core. It also drives the aggregate output for that (core, pin) pair. A source that becomes active while masked is not delivered; it is held as deferred-pending instead. When software later raises the enable bit, the held source is replayed as a fresh assertion. All registers are 32 bits wide and are reached through a word-addressed port with a combinational read path. The default build has 256 sources, 4 cores and 4 pins per core.

Top module: `ext_irq_router`

## Requirements
- R1: A synchronous active-high reset clears every register, status bit, pending bit and output, so `irq_out` and every register read return 0.
- R2: The destination core of source s is the lowest set bit of the low nibble of byte (s mod 4) of core-map word s/4. The core-map words sit at byte offsets 0x400 upward (word address 0x100 + s/4). An all-zero nibble selects core 0.
- R3: The destination pin of source s is taken from group g = s/32. It is the lowest set bit of the low nibble of byte (g mod 4) of pin-map word g/4, at byte offset 0x0C0 upward (word address 0x030). An all-zero nibble selects pin 0.
- R4: When an enabled source goes from 0 to 1, its bit is set in the status word of its destination core, at word s/32 and bit s mod 32. On the next clock edge `irq_out[core*NUM_PIN + pin]` goes high. The enable words sit at byte offset 0x200 upward (word address 0x080 + s/32).
- R5: An output stays high while at least one delivered source routed to that (core, pin) pair remains active. It falls in the cycle after the last such source clears.
- R6: A source that goes from 0 to 1 while its enable bit is 0 is not delivered. It becomes deferred-pending and no output changes.
- R7: An enable-word write delivers every source whose enable bit goes from 0 to 1 and whose deferred-pending bit is set, and then clears that pending bit. Bits that were already 1 deliver nothing.
- R8: When a source goes to 0, its status bit clears in every core and it leaves its aggregate output. If the source was masked, its pending bit also clears, so a later enable delivers nothing.
- R9: A pin-map write moves every source whose status bit is set onto the output for its new pin, from the next cycle on.
- R10: The status region lies at byte offsets 0x800 to 0xBFF. A read there takes the core from offset bits [9:8] and the word from offset bits [4:2], and requires offset bits [7:5] to be 0. Status words ignore writes.
- R11: Node-type words (byte 0x000, 16 words), bounce words (byte 0x280), enable, pin-map and core-map words all read back the last value written.
- R12: A write to an unmapped offset changes nothing, and a read from an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 10 | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | NUM_CORE*NUM_PIN | Aggregate outputs, index core*NUM_PIN + pin |

## Verification
The assertions assume that the sources are already synchronous to `clk`. They also assume that `bus_wr` lasts one cycle per write and that reset is held for at least one edge before any check counts. The bench changes `src_in` and the bus only just after a rising edge, and it keeps each write strobe to a single cycle. In its random phase it still mixes enable, pin-map and core-map writes with source toggles in the same cycles. This covers the case where an enable write and a source edge land together, which the design resolves with the newly written enable value.

// File: rtl/ric_pkg.sv
package ric_pkg;
   localparam int REG_W = 32;
   localparam int WADDR_W = 10;
   localparam int NODE_WORDS = 16;

   // word-address bases of the register regions
   localparam logic [WADDR_W-1:0] NODE_WBASE = 10'h000;
   localparam logic [WADDR_W-1:0] PMAP_WBASE = 10'h030;
   localparam logic [WADDR_W-1:0] EN_WBASE   = 10'h080;
   localparam logic [WADDR_W-1:0] BNC_WBASE  = 10'h0A0;
   localparam logic [WADDR_W-1:0] CMAP_WBASE = 10'h100;

   // lowest set bit of a routing nibble, zero nibble falls back to 0
   function automatic logic [1:0] low_one(input logic [3:0] nib);
      if (nib[0])      return 2'd0;
      else if (nib[1]) return 2'd1;
      else if (nib[2]) return 2'd2;
      else if (nib[3]) return 2'd3;
      else             return 2'd0;
   endfunction
endpackage

// File: rtl/ric_win.sv
module ric_win #(
   parameter logic [9:0] FIRST = 10'h000,
   parameter int         COUNT = 1
) (
   input  logic [9:0] waddr,
   output logic       hit,
   output logic [9:0] off
);
   assign off = waddr - FIRST;
   assign hit = (waddr >= FIRST) && (off < 10'(COUNT));
endmodule

// File: rtl/ric_regs.sv
module ric_regs
   import ric_pkg::*;
#(
   parameter int NUM_SRC  = 256,
   parameter int NUM_CORE = 4,
   parameter int NUM_PIN  = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bus_wr,
   input  logic [WADDR_W-1:0]         bus_addr,
   input  logic [REG_W-1:0]           bus_wdata,
   output logic [REG_W-1:0]           cfg_rdata,
   output logic [NUM_SRC-1:0]         en_next,
   output logic [NUM_SRC-1:0]         en_rise,
   output logic [NUM_SRC-1:0][1:0]    src_core,
   output logic [NUM_SRC-1:0][1:0]    src_pin
);
   localparam int NWORD      = NUM_SRC / 32;
   localparam int PMAP_WORDS = (NWORD + 3) / 4;
   localparam int CMAP_WORDS = NUM_SRC / 4;

   logic [REG_W-1:0] node_q [NODE_WORDS];
   logic [REG_W-1:0] pmap_q [PMAP_WORDS];
   logic [REG_W-1:0] en_q   [NWORD];
   logic [REG_W-1:0] bnc_q  [NWORD];
   logic [REG_W-1:0] cmap_q [CMAP_WORDS];

   logic       node_hit, pmap_hit, en_hit, bnc_hit, cmap_hit;
   logic [9:0] node_off, pmap_off, en_off, bnc_off, cmap_off;

   ric_win #(.FIRST(NODE_WBASE), .COUNT(NODE_WORDS)) u_win_node
      (.waddr(bus_addr), .hit(node_hit), .off(node_off));
   ric_win #(.FIRST(PMAP_WBASE), .COUNT(PMAP_WORDS)) u_win_pmap
      (.waddr(bus_addr), .hit(pmap_hit), .off(pmap_off));
   ric_win #(.FIRST(EN_WBASE), .COUNT(NWORD)) u_win_en
      (.waddr(bus_addr), .hit(en_hit), .off(en_off));
   ric_win #(.FIRST(BNC_WBASE), .COUNT(NWORD)) u_win_bnc
      (.waddr(bus_addr), .hit(bnc_hit), .off(bnc_off));
   ric_win #(.FIRST(CMAP_WBASE), .COUNT(CMAP_WORDS)) u_win_cmap
      (.waddr(bus_addr), .hit(cmap_hit), .off(cmap_off));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int w = 0; w < NODE_WORDS; w++) node_q[w] <= '0;
         for (int w = 0; w < PMAP_WORDS; w++) pmap_q[w] <= '0;
         for (int w = 0; w < NWORD; w++) begin
            en_q[w]  <= '0;
            bnc_q[w] <= '0;
         end
         for (int w = 0; w < CMAP_WORDS; w++) cmap_q[w] <= '0;
      end else if (bus_wr) begin
         for (int w = 0; w < NODE_WORDS; w++)
            if (node_hit && node_off == 10'(w)) node_q[w] <= bus_wdata;
         for (int w = 0; w < PMAP_WORDS; w++)
            if (pmap_hit && pmap_off == 10'(w)) pmap_q[w] <= bus_wdata;
         for (int w = 0; w < NWORD; w++) begin
            if (en_hit && en_off == 10'(w))   en_q[w]  <= bus_wdata;
            if (bnc_hit && bnc_off == 10'(w)) bnc_q[w] <= bus_wdata;
         end
         for (int w = 0; w < CMAP_WORDS; w++)
            if (cmap_hit && cmap_off == 10'(w)) cmap_q[w] <= bus_wdata;
      end
   end

   // enable value seen by the source logic in the cycle of a write
   for (genvar w = 0; w < NWORD; w++) begin : g_en
      logic [REG_W-1:0] nxt;
      assign nxt = (bus_wr && en_hit && en_off == 10'(w)) ? bus_wdata : en_q[w];
      assign en_next[w*32 +: 32] = nxt;
      assign en_rise[w*32 +: 32] = nxt & ~en_q[w];

      assert_en_wb_R11: assert property (@(posedge clk) disable iff (rst)
         (bus_wr && en_hit && en_off == 10'(w)) |=> (en_q[w] == $past(bus_wdata)));
   end

   // routing decode, clamped when fewer than four cores or pins exist
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
      logic [1:0] c_raw, p_raw;
      assign c_raw = low_one(cmap_q[s/4][(s%4)*8 +: 4]);
      assign p_raw = low_one(pmap_q[(s/32)/4][((s/32)%4)*8 +: 4]);
      if (NUM_CORE == 4) begin : g_c_full
         assign src_core[s] = c_raw;
      end else begin : g_c_clamp
         assign src_core[s] = (c_raw < 2'(NUM_CORE)) ? c_raw : 2'd0;
      end
      if (NUM_PIN == 4) begin : g_p_full
         assign src_pin[s] = p_raw;
      end else begin : g_p_clamp
         assign src_pin[s] = (p_raw < 2'(NUM_PIN)) ? p_raw : 2'd0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int w = 0; w < NODE_WORDS; w++)
         if (node_hit && node_off == 10'(w)) cfg_rdata = node_q[w];
      for (int w = 0; w < PMAP_WORDS; w++)
         if (pmap_hit && pmap_off == 10'(w)) cfg_rdata = pmap_q[w];
      for (int w = 0; w < NWORD; w++) begin
         if (en_hit && en_off == 10'(w))   cfg_rdata = en_q[w];
         if (bnc_hit && bnc_off == 10'(w)) cfg_rdata = bnc_q[w];
      end
      for (int w = 0; w < CMAP_WORDS; w++)
         if (cmap_hit && cmap_off == 10'(w)) cfg_rdata = cmap_q[w];
   end
endmodule

// File: rtl/ric_track.sv
module ric_track #(
   parameter int NUM_SRC  = 256,
   parameter int NUM_CORE = 4
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [NUM_SRC-1:0]                src_in,
   input  logic [NUM_SRC-1:0]                en_next,
   input  logic [NUM_SRC-1:0]                en_rise,
   input  logic [NUM_SRC-1:0][1:0]           src_core,
   output logic [NUM_CORE-1:0][NUM_SRC-1:0]  stat
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic                raw_q, pend_q;
      logic [NUM_CORE-1:0] col_q, dest;

      for (genvar c = 0; c < NUM_CORE; c++) begin : g_dest
         assign dest[c]    = (src_core[s] == 2'(c));
         assign stat[c][s] = col_q[c];
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            raw_q  <= 1'b0;
            pend_q <= 1'b0;
            col_q  <= '0;
         end else begin
            raw_q <= src_in[s];
            if (!src_in[s]) begin
               pend_q <= 1'b0;
               col_q  <= '0;
            end else if (!raw_q) begin
               if (en_next[s]) col_q  <= dest;
               else            pend_q <= 1'b1;
            end else if (en_rise[s] && pend_q) begin
               col_q  <= dest;
               pend_q <= 1'b0;
            end
         end
      end

      assert_fall_clear_R8: assert property (@(posedge clk) disable iff (rst)
         !src_in[s] |=> (!pend_q && col_q == '0));
      assert_masked_rise_R6: assert property (@(posedge clk) disable iff (rst)
         (src_in[s] && !raw_q && !en_next[s]) |=> (pend_q && col_q == '0));
      assert_single_core_R4: assert property (@(posedge clk) disable iff (rst)
         $onehot0(col_q));
   end
endmodule

// File: rtl/ric_agg.sv
module ric_agg #(
   parameter int NUM_SRC  = 256,
   parameter int NUM_CORE = 4,
   parameter int NUM_PIN  = 4
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [NUM_CORE-1:0][NUM_SRC-1:0]  stat,
   input  logic [NUM_SRC-1:0][1:0]           src_pin,
   output logic [NUM_CORE*NUM_PIN-1:0]       irq
);
   for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic [NUM_SRC-1:0] sel;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
         assign sel[s] = (src_pin[s] == 2'(p));
      end
      for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
         assign irq[c*NUM_PIN + p] = |(stat[c] & sel);
      end
   end

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_chk
      assert_core_any_R5: assert property (@(posedge clk) disable iff (rst)
         (|stat[c]) == (|irq[c*NUM_PIN +: NUM_PIN]));
   end
endmodule

// File: rtl/ext_irq_router.sv
module ext_irq_router
   import ric_pkg::*;
#(
   parameter int NUM_SRC  = 256,
   parameter int NUM_CORE = 4,
   parameter int NUM_PIN  = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_SRC-1:0]          src_in,
   input  logic                        bus_wr,
   input  logic [WADDR_W-1:0]          bus_addr,
   input  logic [REG_W-1:0]            bus_wdata,
   output logic [REG_W-1:0]            bus_rdata,
   output logic [NUM_CORE*NUM_PIN-1:0] irq_out
);
   localparam int NWORD = NUM_SRC / 32;

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 256) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 between 32 and 256");
   end
   if (NUM_CORE < 1 || NUM_CORE > 4) begin : g_bad_core
      $error("NUM_CORE must lie in 1..4");
   end
   if (NUM_PIN < 1 || NUM_PIN > 4) begin : g_bad_pin
      $error("NUM_PIN must lie in 1..4");
   end

   logic [REG_W-1:0]                 cfg_rdata;
   logic [NUM_SRC-1:0]               en_next, en_rise;
   logic [NUM_SRC-1:0][1:0]          src_core, src_pin;
   logic [NUM_CORE-1:0][NUM_SRC-1:0] stat;

   ric_regs #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_regs (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cfg_rdata(cfg_rdata), .en_next(en_next),
      .en_rise(en_rise), .src_core(src_core), .src_pin(src_pin));

   ric_track #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_track (
      .clk(clk), .rst(rst), .src_in(src_in), .en_next(en_next),
      .en_rise(en_rise), .src_core(src_core), .stat(stat));

   ric_agg #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_agg (
      .clk(clk), .rst(rst), .stat(stat), .src_pin(src_pin), .irq(irq_out));

   // status region: word address bits [9:8]=2'b10, core in [7:6], word in [2:0]
   always_comb begin
      bus_rdata = cfg_rdata;
      if (bus_addr[9:8] == 2'b10) begin
         bus_rdata = '0;
         if (bus_addr[5:3] == 3'b000) begin
            for (int c = 0; c < NUM_CORE; c++)
               for (int w = 0; w < NWORD; w++)
                  if (bus_addr[7:6] == 2'(c) && bus_addr[2:0] == 3'(w))
                     bus_rdata = stat[c][w*32 +: 32];
         end
      end
   end
endmodule

// File: tb/ext_irq_router_tb.sv
`timescale 1ns/100ps
module ext_irq_router_tb;
   localparam int NS = 256;
   localparam int NC = 4;
   localparam int NP = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NS-1:0]     src_in = '0;
   logic              bus_wr = 1'b0;
   logic [9:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NC*NP-1:0]  irq_out;

   int errors = 0;
   int checks = 0;
   bit started = 0;
   bit done = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   ext_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) u_dut (
      .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out));

   // ---------------- behavioural reference model ----------------
   bit [NS-1:0] m_raw, m_en, m_pend, en_new;
   bit [NS-1:0] m_stat [NC];
   bit [31:0]   m_node [16];
   bit [31:0]   m_pmap [2];
   bit [31:0]   m_bnc  [8];
   bit [31:0]   m_cmap [64];

   function automatic int nib_low(bit [31:0] v);
      for (int i = 0; i < 4; i++) if (v[i]) return i;
      return 0;
   endfunction
   function automatic int core_of(int s);
      return nib_low(m_cmap[s/4] >> ((s%4)*8));
   endfunction
   function automatic int pin_of(int s);
      int g = s / 32;
      return nib_low(m_pmap[g/4] >> ((g%4)*8));
   endfunction
   function automatic bit [31:0] m_read(int wa);
      if (wa < 16) return m_node[wa];
      if (wa >= 'h30 && wa < 'h32) return m_pmap[wa-'h30];
      if (wa >= 'h80 && wa < 'h88) return m_en[(wa-'h80)*32 +: 32];
      if (wa >= 'hA0 && wa < 'hA8) return m_bnc[wa-'hA0];
      if (wa >= 'h100 && wa < 'h140) return m_cmap[wa-'h100];
      if (wa >= 'h200 && wa < 'h300 && ((wa >> 3) & 7) == 0)
         return m_stat[(wa >> 6) & 3][(wa & 7)*32 +: 32];
      return 0;
   endfunction
   function automatic bit [NC*NP-1:0] m_irq();
      bit [NC*NP-1:0] r = '0;
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < NS; s++)
            if (m_stat[c][s]) r[c*NP + pin_of(s)] = 1'b1;
      return r;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_raw = '0; m_en = '0; m_pend = '0;
         for (int c = 0; c < NC; c++) m_stat[c] = '0;
         for (int i = 0; i < 16; i++) m_node[i] = '0;
         for (int i = 0; i < 2; i++) m_pmap[i] = '0;
         for (int i = 0; i < 8; i++) m_bnc[i] = '0;
         for (int i = 0; i < 64; i++) m_cmap[i] = '0;
      end else begin
         int wa;
         wa = int'(bus_addr);
         en_new = m_en;
         if (bus_wr && wa >= 'h80 && wa < 'h88) en_new[(wa-'h80)*32 +: 32] = bus_wdata;
         for (int s = 0; s < NS; s++) begin
            if (!src_in[s]) begin
               m_pend[s] = 0;
               for (int c = 0; c < NC; c++) m_stat[c][s] = 0;
            end else if (!m_raw[s]) begin
               if (en_new[s]) m_stat[core_of(s)][s] = 1;
               else m_pend[s] = 1;
            end else if (en_new[s] && !m_en[s] && m_pend[s]) begin
               m_stat[core_of(s)][s] = 1;
               m_pend[s] = 0;
            end
         end
         if (bus_wr) begin
            if (wa < 16) m_node[wa] = bus_wdata;
            else if (wa >= 'h30 && wa < 'h32) m_pmap[wa-'h30] = bus_wdata;
            else if (wa >= 'hA0 && wa < 'hA8) m_bnc[wa-'hA0] = bus_wdata;
            else if (wa >= 'h100 && wa < 'h140) m_cmap[wa-'h100] = bus_wdata;
         end
         m_en = en_new;
         m_raw = src_in;
      end
   end

   // compare against the model every cycle, away from the rising edge
   always @(negedge clk) begin
      if (started && !rst && !done) begin
         bit [NC*NP-1:0] ei;
         bit [31:0] er;
         ei = m_irq();
         er = m_read(int'(bus_addr));
         checks += 2;
         if (irq_out !== ei) begin
            errors++;
            $display("FAIL %s model irq_out actual=%h expected=%h", phase, irq_out, ei);
         end
         if (bus_rdata !== er) begin
            errors++;
            $display("FAIL %s model read @%h actual=%h expected=%h", phase, bus_addr, bus_rdata, er);
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask
   task automatic wr(int wa, logic [31:0] d);
      bus_addr = 10'(wa); bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask
   task automatic rd(string tag, int wa, logic [31:0] exp);
      bus_addr = 10'(wa);
      #0.5;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      started = 1;
      // R1: reset state
      chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
      rd("R1 enable word after reset", 'h80, 32'h0);
      rd("R1 status word after reset", 'h280, 32'h0);

      // routing setup
      phase = "R2";
      wr('h101, 32'h0000_0C00);     // source 5 -> core 2, source 6 zero nibble -> core 0
      wr('h030, 32'h0000_080A);     // group 0 -> pin 1, group 1 -> pin 3
      wr('h080, 32'h0000_0060);     // enable sources 5, 6
      wr('h081, 32'h0000_0001);     // enable source 32

      phase = "R4";
      src_in[5] = 1'b1; tick();
      chk("R4 src5 to core2 pin1", 32'(irq_out), 32'h0200);
      rd("R10 status core2 word0", 'h280, 32'h0000_0020);
      src_in[6] = 1'b1; src_in[32] = 1'b1; tick();
      chk("R2 zero nibble core0, R3 group pins", 32'(irq_out), 32'h020A);
      rd("R10 status core0 word1", 'h201, 32'h0000_0001);

      phase = "R6";
      src_in[7] = 1'b1; tick();
      chk("R6 masked source not delivered", 32'(irq_out), 32'h020A);
      rd("R6 status core0 word0", 'h200, 32'h0000_0040);
      phase = "R7";
      wr('h080, 32'h0000_00E0);
      rd("R7 replay on enable rise", 'h200, 32'h0000_00C0);
      phase = "R5";
      src_in[6] = 1'b0; tick();
      chk("R5 pin held by remaining source", 32'(irq_out), 32'h020A);
      src_in[7] = 1'b0; tick();
      chk("R5 pin drops with last source", 32'(irq_out), 32'h0208);
      rd("R8 status cleared on deassert", 'h200, 32'h0);

      phase = "R8";
      src_in[9] = 1'b1; tick();
      src_in[9] = 1'b0; tick();
      wr('h080, 32'h0000_02E0);
      rd("R8 stale pending not delivered", 'h200, 32'h0);
      chk("R8 outputs unchanged", 32'(irq_out), 32'h0208);
      phase = "R7";
      wr('h080, 32'h0000_02E0);
      chk("R7 rewrite of set bits no delivery", 32'(irq_out), 32'h0208);

      phase = "R9";
      wr('h030, 32'h0000_0804);
      chk("R9 src5 moved to core2 pin2", 32'(irq_out), 32'h0408);

      phase = "R3";
      wr('h110, 32'h0000_0008);     // source 64 -> core 3
      wr('h082, 32'h0000_0001);
      src_in[64] = 1'b1; tick();
      chk("R3 zero pin nibble selects pin0", 32'(irq_out), 32'h1408);

      phase = "R12";
      wr('h0C0, 32'hFFFF_FFFF);
      rd("R12 unmapped read zero", 'h0C0, 32'h0);
      wr('h280, 32'h0);
      rd("R10 status ignores write", 'h280, 32'h0000_0020);
      rd("R12 top of map reads zero", 'h3FF, 32'h0);
      rd("R10 status hole reads zero", 'h238, 32'h0);
      chk("R12 outputs unchanged", 32'(irq_out), 32'h1408);

      phase = "R11";
      wr('h001, 32'h1234_5678);
      rd("R11 node type readback", 'h001, 32'h1234_5678);
      wr('hA1, 32'hCAFE_F00D);
      rd("R11 bounce readback", 'hA1, 32'hCAFE_F00D);
      rd("R11 pin map readback", 'h030, 32'h0000_0804);
      rd("R11 core map readback", 'h110, 32'h0000_0008);

      // random phase, checked by the model on every cycle
      phase = "R5";
      for (int n = 0; n < 3000; n++) begin
         int s;
         int k;
         s = ($urandom % 2 == 0) ? int'($urandom % 64) : 192 + int'($urandom % 64);
         if ($urandom % 3 == 0) src_in[s] = ~src_in[s];
         k = int'($urandom % 16);
         bus_wr = 1'b0;
         bus_addr = 10'($urandom % 'h300);
         if (k == 0) begin
            bus_wr = 1'b1; bus_addr = 10'('h80 + $urandom % 8); bus_wdata = $urandom;
         end else if (k == 1) begin
            bus_wr = 1'b1; bus_addr = 10'('h30 + $urandom % 2); bus_wdata = $urandom;
         end else if (k == 2) begin
            bus_wr = 1'b1;
            bus_addr = 10'('h100 + (($urandom % 2 == 0) ? $urandom % 16 : 48 + $urandom % 16));
            bus_wdata = $urandom;
         end else if (k == 3) begin
            bus_addr = 10'('h200 + $urandom % 256);
         end
         tick();
      end
      bus_wr = 1'b0;
      tick();

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule